// File: doc/BRIEF.md
# Condition Field Masked LUT Unit

This block rewrites one 4-bit field of a 32-bit condition register. The register holds eight fields, and field 0 is the most significant nibble. Each operation names a destination field and two further fields. For every bit position the unit forms a small index from the matching bits of those fields and looks the index up in a truth table. A 4-bit write mask then chooses which destination bits take the new value. All other bits of the register pass through unchanged.

There are two modes. In ternary mode the index has three bits, taken from the destination, the first source and the second source fields, and the table is an 8-bit immediate. In binary mode the index has two bits, taken from the destination and the first source fields, and the table is the contents of the second source field. A binary operation with an all-zero mask is illegal: the unit raises a trap and returns the register unmodified.

An operation presented with `op_valid` appears on the outputs one clock later, qualified by `res_valid`.

Top module: `cfl_unit`

## Requirements
- R1: Field index f selects register bits [31-4f : 28-4f]. Field 0 is bits [31:28] and field 7 is bits [3:0]. Within a field, bit k is the bit of weight 2^k.
- R2: In ternary mode (`op_mode`=0), bit k of the result is `tbl_imm[{D[k],A[k],B[k]}]`. D, A and B are the destination, first source and second source fields. `tbl_imm` bit 0 is its least significant bit.
- R3: In binary mode (`op_mode`=1), bit k of the result is `B[{D[k],A[k]}]`, so the second source field serves as a 4-entry table indexed from its least significant bit.
- R4: Destination bit k takes the result bit only when `wr_mask[k]` is 1. Otherwise it keeps its prior value.
- R5: Every register bit outside the destination field leaves the unit equal to its input value.
- R6: A binary-mode operation with `wr_mask`=0 sets `trap` for that result and returns `cr_out` equal to `cr_in`.
- R7: A ternary-mode operation with `wr_mask`=0 does not trap and returns the register unchanged.
- R8: When the destination index equals a source index, or the two source indices are equal, every index and table bit comes from the register value before the update.
- R9: `res_valid` rises one cycle after an accepted `op_valid`. In a cycle that follows no operation, `res_valid` and `trap` are 0 and `cr_out` holds its previous value.
- R10: While `rst_n` is low, `res_valid`, `trap` and `cr_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_mode | input | 1 | 0 = ternary immediate table, 1 = binary table taken from a field |
| cr_in | input | 32 | Condition register value before the update |
| dst_idx | input | 3 | Destination field index |
| srca_idx | input | 3 | First source field index |
| srcb_idx | input | 3 | Second source field index; in binary mode, the field used as the table |
| tbl_imm | input | 8 | Ternary truth table |
| wr_mask | input | 4 | Per-bit write enable for the destination field |
| res_valid | output | 1 | Result present |
| cr_out | output | 32 | Updated condition register |
| trap | output | 1 | Illegal binary operation (all-zero mask) |

## Verification
Two things can fall in the same cycle: writing the destination field and reading that same field as an index source or as the binary table. The sweep covers all 512 combinations of the three indices in both modes, including every aliased case. The reference model reads each index bit from a snapshot of the register taken before any bit is written. A second collision happens between a binary operation and an all-zero mask, where trap must win over the update. Because the mask cycles through all 16 values during the binary sweep, this collision recurs often. Each such result is judged on both the raised trap and an untouched register.

// File: rtl/cfl_pkg.sv
// Shared definitions for the condition field LUT unit.
// Assumes: one mode bit selects between the two table sources.
package cfl_pkg;
    typedef enum logic {
        MODE_TERNARY = 1'b0,
        MODE_BINARY  = 1'b1
    } cfl_mode_e;

    // Number of index bits used in ternary mode.
    localparam int TERN_IDX_W = 3;
    // Number of index bits used in binary mode.
    localparam int BIN_IDX_W  = 2;
endpackage

// File: rtl/cfl_field_sel.sv
// Extracts one field from the flat register.
// Assumes: field 0 is the most significant field.
module cfl_field_sel #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]    cr,
    input  logic [IDX_W-1:0]   idx,
    output logic [FIELD_W-1:0] field
);
    logic [FIELD_W-1:0] fields [NUM_FIELDS];

    // Split the register into fields, field 0 at the top.
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_split
        assign fields[f] = cr[CR_W-1-f*FIELD_W -: FIELD_W];
    end

    // Pick the indexed field.
    always_comb begin
        field = fields[idx];
    end
endmodule

// File: rtl/cfl_lut_eval.sv
// Per-bit table lookup for both modes.
// Assumes: FIELD_W >= 4, so a field can hold a 2-input table.
module cfl_lut_eval
    import cfl_pkg::*;
#(
    parameter int FIELD_W = 4,
    localparam int IMM_W  = 2 ** TERN_IDX_W
) (
    input  cfl_mode_e          mode,
    input  logic [FIELD_W-1:0] dst_f,
    input  logic [FIELD_W-1:0] srca_f,
    input  logic [FIELD_W-1:0] srcb_f,
    input  logic [IMM_W-1:0]   imm,
    output logic [FIELD_W-1:0] result
);
    for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
        logic [TERN_IDX_W-1:0] t_idx;
        logic [BIN_IDX_W-1:0]  b_idx;

        // Build both lookup indices from the bits at position k.
        always_comb begin
            t_idx = {dst_f[k], srca_f[k], srcb_f[k]};
            b_idx = {dst_f[k], srca_f[k]};
        end

        // Choose the table named by the mode.
        always_comb begin
            if (mode == MODE_TERNARY) result[k] = imm[t_idx];
            else                      result[k] = srcb_f[b_idx];
        end
    end
endmodule

// File: rtl/cfl_field_merge.sv
// Applies the bit mask to the destination field and writes it back into the register.
// Assumes: old_f is the current value of field dst_idx.
module cfl_field_merge #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]    cr,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic [FIELD_W-1:0] old_f,
    input  logic [FIELD_W-1:0] new_f,
    input  logic [FIELD_W-1:0] mask,
    output logic [CR_W-1:0]    cr_new
);
    logic [FIELD_W-1:0] merged;

    // Keep masked-off bits, take masked-on bits from the result.
    always_comb begin
        merged = (old_f & ~mask) | (new_f & mask);
    end

    // Replace only the destination field.
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_put
        assign cr_new[CR_W-1-f*FIELD_W -: FIELD_W] =
            (dst_idx == IDX_W'(f)) ? merged : cr[CR_W-1-f*FIELD_W -: FIELD_W];
    end
endmodule

// File: rtl/cfl_unit.sv
// Condition field masked LUT unit, top level.
// Computes one field update per accepted operation and registers the result once.
// Assumes: a synchronous active-low reset; all reads use the incoming register value.
module cfl_unit
    import cfl_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int IDX_W     = $clog2(NUM_FIELDS),
    localparam int IMM_W     = 2 ** TERN_IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic               op_mode,
    input  logic [CR_W-1:0]    cr_in,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic [IDX_W-1:0]   srca_idx,
    input  logic [IDX_W-1:0]   srcb_idx,
    input  logic [IMM_W-1:0]   tbl_imm,
    input  logic [FIELD_W-1:0] wr_mask,
    output logic               res_valid,
    output logic [CR_W-1:0]    cr_out,
    output logic               trap
);
    cfl_mode_e          mode;
    logic [FIELD_W-1:0] dst_f, srca_f, srcb_f, lut_res;
    logic [CR_W-1:0]    cr_upd;
    logic               illegal;

    // Convert the mode pin to the enum type.
    always_comb begin
        mode = cfl_mode_e'(op_mode);
    end

    cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_dst (
        .cr(cr_in), .idx(dst_idx), .field(dst_f)
    );
    cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_a (
        .cr(cr_in), .idx(srca_idx), .field(srca_f)
    );
    cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sel_b (
        .cr(cr_in), .idx(srcb_idx), .field(srcb_f)
    );

    cfl_lut_eval #(.FIELD_W(FIELD_W)) u_eval (
        .mode(mode), .dst_f(dst_f), .srca_f(srca_f), .srcb_f(srcb_f),
        .imm(tbl_imm), .result(lut_res)
    );

    cfl_field_merge #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_merge (
        .cr(cr_in), .dst_idx(dst_idx), .old_f(dst_f), .new_f(lut_res),
        .mask(wr_mask), .cr_new(cr_upd)
    );

    // Flag a binary operation that would write no bit.
    always_comb begin
        illegal = (mode == MODE_BINARY) && (wr_mask == '0);
    end

    // Result register: capture on an operation, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            trap      <= 1'b0;
            cr_out    <= '0;
        end else begin
            res_valid <= op_valid;
            trap      <= op_valid && illegal;
            if (op_valid) cr_out <= illegal ? cr_in : cr_upd;
        end
    end
endmodule

// File: rtl/cfl_unit_chk.sv
// Temporal checks for cfl_unit, attached with bind.
// Assumes: the same parameters as the bound instance.
module cfl_unit_chk #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int CR_W      = NUM_FIELDS * FIELD_W,
    localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic               op_mode,
    input logic [CR_W-1:0]    cr_in,
    input logic [IDX_W-1:0]   dst_idx,
    input logic [FIELD_W-1:0] wr_mask,
    input logic               res_valid,
    input logic [CR_W-1:0]    cr_out,
    input logic               trap
);
    // R9: a result follows an accepted operation.
    p_valid_follows_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid));

    // R9: an idle cycle leaves the outputs quiet and the register held.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !trap && $stable(cr_out)));

    // R6: a trap only follows a binary operation with an empty mask.
    p_trap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> ($past(op_valid) && $past(op_mode) && ($past(wr_mask) == '0)));

    // R6: a trapped result returns the input register.
    p_trap_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (cr_out == $past(cr_in)));

    // R7: a ternary operation never traps.
    p_tern_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_mode) |=> !trap);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        // R5: fields other than the destination pass through.
        p_other_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && ($past(dst_idx) != IDX_W'(f)))
            |-> (cr_out[CR_W-1-f*FIELD_W -: FIELD_W] == $past(cr_in[CR_W-1-f*FIELD_W -: FIELD_W])));
        for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
            // R4: a masked-off destination bit is kept.
            p_mask_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && ($past(dst_idx) == IDX_W'(f)) && !$past(wr_mask[k]))
                |-> (cr_out[CR_W-FIELD_W-f*FIELD_W+k] == $past(cr_in[CR_W-FIELD_W-f*FIELD_W+k])));
        end
    end
endmodule

bind cfl_unit cfl_unit_chk #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
    .cr_in(cr_in), .dst_idx(dst_idx), .wr_mask(wr_mask),
    .res_valid(res_valid), .cr_out(cr_out), .trap(trap)
);

// File: tb/sim_cfl_unit.sv
// Scoreboard bench for cfl_unit: a driver queues expected results and a monitor compares them.
module sim_cfl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_mode = 1'b0;
    logic [31:0] cr_in = '0;
    logic [2:0]  dst_idx = '0, srca_idx = '0, srcb_idx = '0;
    logic [7:0]  tbl_imm = '0;
    logic [3:0]  wr_mask = '0;
    logic        res_valid, trap;
    logic [31:0] cr_out;

    typedef struct {
        logic [31:0] cr;
        logic        trap;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          failures = 0;
    logic [31:0] last_cr = '0;
    bit          done = 0;

    always #2 clk = ~clk;

    cfl_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .cr_in(cr_in), .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
        .tbl_imm(tbl_imm), .wr_mask(wr_mask),
        .res_valid(res_valid), .cr_out(cr_out), .trap(trap)
    );

    // Register bit at MSB-first position p of field f (R1).
    function automatic logic crbit(logic [31:0] cr, int f, int p);
        return cr[31 - (4*f + p)];
    endfunction

    // Reference model, working on a snapshot of the register taken before any write (R8).
    function automatic exp_t model(logic [31:0] cr, int d, int a, int b,
                                   logic [7:0] imm, logic [3:0] msk, logic md);
        exp_t e;
        e.cr = cr;
        e.trap = 1'b0;
        if (md && msk == 4'b0000) begin
            e.trap = 1'b1;
            return e;
        end
        for (int p = 0; p < 4; p++) begin
            logic r;
            logic bd, ba, bb;
            bd = crbit(cr, d, p);
            ba = crbit(cr, a, p);
            bb = crbit(cr, b, p);
            if (!md) begin
                int ti;
                ti = {29'd0, bd, ba, bb};
                r = imm[ti];
            end else begin
                int bi;
                bi = {30'd0, bd, ba};
                r = crbit(cr, b, 3 - bi);
            end
            if (msk[3 - p]) e.cr[31 - (4*d + p)] = r;
        end
        return e;
    endfunction

    task automatic drive_op(logic md, int d, int a, int b,
                            logic [7:0] imm, logic [3:0] msk, logic [31:0] cr);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1;
        op_mode  = md;
        dst_idx  = 3'(d);
        srca_idx = 3'(a);
        srcb_idx = 3'(b);
        tbl_imm  = imm;
        wr_mask  = msk;
        cr_in    = cr;
        e = model(cr, d, a, b, imm, msk, md);
        if (e.trap)                e.tag = "R6";
        else if (!md && msk == 0)  e.tag = "R7";
        else if (!md)              e.tag = "R1 R2 R4 R5";
        else                       e.tag = "R1 R3 R4 R5";
        if (d == a || d == b || a == b) e.tag = {e.tag, " R8"};
        sb_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            cr_in    = $urandom;
            wr_mask  = 4'($urandom);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Monitor: pop and compare each result; check idle cycles against the held value.
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (res_valid) begin
                exp_t e;
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R9 unexpected result: cr_out=%h expected no result", cr_out);
                end else begin
                    e = sb_q.pop_front();
                    if (cr_out !== e.cr || trap !== e.trap) begin
                        failures++;
                        $display("FAIL %s cr_out=%h trap=%b expected cr_out=%h trap=%b",
                                 e.tag, cr_out, trap, e.cr, e.trap);
                    end
                end
                last_cr = cr_out;
            end else begin
                checks++;
                if (trap !== 1'b0 || cr_out !== last_cr) begin
                    failures++;
                    $display("FAIL R9 idle cr_out=%h trap=%b expected cr_out=%h trap=0",
                             cr_out, trap, last_cr);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired, expected run to finish");
            summary();
            $finish;
        end
    end

    // Driver: reset, then sweep every index triple in both modes.
    initial begin
        int m;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (res_valid !== 1'b0 || trap !== 1'b0 || cr_out !== 32'h0) begin
            failures++;
            $display("FAIL R10 reset res_valid=%b trap=%b cr_out=%h expected 0 0 00000000",
                     res_valid, trap, cr_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: field 0 upper nibble, ternary AND of all three fields (R2).
        drive_op(1'b0, 0, 1, 2, 8'h80, 4'hF, 32'hF3A0_0000);
        // Directed: binary XOR table held in field 7, destination field 7 (R3, R8).
        drive_op(1'b1, 7, 3, 7, 8'h00, 4'hF, 32'h0000_C006);
        idle(2);

        m = 0;
        for (int d = 0; d < 8; d++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    drive_op(1'b0, d, a, b, 8'($urandom), 4'(m), $urandom);
                    m++;
                    if ((m % 37) == 0) idle(1);
                end
        for (int d = 0; d < 8; d++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    drive_op(1'b1, d, a, b, 8'($urandom), 4'(m), $urandom);
                    m++;
                    if ((m % 41) == 0) idle(2);
                end
        // Trap right after a normal write, then a held idle (R6, R9).
        drive_op(1'b1, 2, 5, 6, 8'h00, 4'h0, 32'h1234_5678);
        idle(4);

        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R9 missing results: %0d pending expected 0", sb_q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule